// File: doc/BRIEF.md
# Reset-Time Startup Configuration Latch

This block captures a 16-bit startup configuration word from a bidirectional data port as a reset ends. A reset sequencer tells it when a reset begins, what kind of reset it is, whether bidirectional reset mode is active, the level of the external-access pin, and when the external reset input rises. From these the block times a closed period, an open period in which chosen port bits are transparent, and a single-cycle capture strobe. Which bits are captured, and which keep their old values, depends on the reset kind and on the bidirectional mode.

The captured word is decoded into registered fields: the CPU clock multiplier, segment-address lines, chip-select lines, write mode, bus width and address multiplexing, a special start mode with an error flag, and the adapt and emulation requests. When a power-on or long hardware reset sees the external-access pin high (single-chip start), a fixed low byte takes the place of the port's low byte, and the adapt and emulation requests stay blocked. Start-up software can overwrite the whole word through a write port until it signals that initialisation is done.

Reset kinds on `rst_kind`: 0 power-on, 1 long hardware, 2 short hardware, 3 software or watchdog. Time is counted in `clk` cycles; `SEQ_TCL` is the length of one internal reset sequence.

Top module: `startup_cfg_latch`

## Requirements
- R1: After `rst`, `cfg_word` is 16'hFFFF, `port_xpar` is 0, `cfg_strobe` is 0, `clk_mult_x2` is 8, `smode` is 0 (normal start), `smode_err`, `adapt_en` and `emu_en` are 0.
- R2: Counting the edge that samples `rst_start` as edge 0, `port_xpar` stays 0 up to edge H-1 and takes its open-period value after edge H, with H = 2*SEQ_TCL for power-on and H = SEQ_TCL for every other kind. A new `rst_start` closes the window and restarts the timing.
- R3: `cfg_strobe` is a one-cycle pulse, and `port_xpar` is 0 while it is high. Let D = PRE_DLY (default 7) when `cfg_word[15:13]` held 3'b001 at `rst_start`, and DIR_DLY (default 10) otherwise. For short-hardware and software resets the strobe follows edge H+D. For power-on and long resets it follows edge max(H, r)+D, where r is the edge that samples `pin_rise`.
- R4: `port_xpar[1:0]` is never 1.
- R5: A short hardware reset with bidirectional mode off captures port bits [12:2] only (open mask 16'h1FFC). All other bits keep their values.
- R6: A software or watchdog reset with bidirectional mode off captures port bits [12:6] only (open mask 16'h1FC0). All other bits keep their values.
- R7: With `bidir_en` high (any kind), or on power-on and long resets, all 16 bits are captured (open mask 16'hFFFC).
- R8: A power-on or long reset with `ext_access` high captures `port_in[15:8]` and loads 8'h2B into the low byte (open mask 16'hFF00). It also blocks `adapt_en` and `emu_en`, even after software writes, until a later power-on or long reset with `ext_access` low.
- R9: `cfg_word[5:2]` sets `smode`: 1111 gives 0 (normal), 1011 gives 1 (loader), 0111 gives 2 (external host), 1110 gives 3 (CPU host), 1010 gives 4 (loader plus CPU host). Any other code gives 0 with `smode_err` high.
- R10: `bus_16bit` = `cfg_word[7]` and `bus_mux` = `cfg_word[6]`. `seg_sel` = bits [12:11], `cs_sel` = bits [10:9], `wr_mode` = bit 8. `adapt_en` is the inverse of bit 1 and `emu_en` the inverse of bit 0, both gated by R8.
- R11: `clk_mult_x2` is twice the clock factor selected by bits [15:13]: 111 gives 8, 110 gives 6, 101 gives 4, 100 gives 10, 011 gives 2, 010 gives 3, 001 gives 1, 000 gives 5.
- R12: While `init_done` is low, `sw_we` loads `sw_data` into `cfg_word` at the next edge. While `init_done` is high, `sw_we` has no effect. A capture strobe takes priority over a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one cycle per TCL |
| rst | input | 1 | Synchronous active-high reset of the block |
| rst_start | input | 1 | Pulse: a reset event begins |
| rst_kind | input | 2 | Reset kind, sampled with rst_start |
| bidir_en | input | 1 | Bidirectional reset mode, sampled with rst_start |
| ext_access | input | 1 | External-access pin level, sampled with rst_start |
| pin_rise | input | 1 | Pulse: external reset input rose |
| port_in | input | 16 | Port levels during reset |
| sw_we | input | 1 | Software write strobe |
| sw_data | input | 16 | Software write data |
| init_done | input | 1 | High once initialisation is finished; locks writes |
| port_xpar | output | 16 | Bits currently transparent |
| cfg_strobe | output | 1 | Capture strobe pulse |
| cfg_word | output | 16 | Held configuration word |
| clk_mult_x2 | output | 4 | Twice the CPU clock factor |
| seg_sel | output | 2 | Segment-address line select |
| cs_sel | output | 2 | Chip-select line select |
| wr_mode | output | 1 | Write configuration |
| bus_16bit | output | 1 | 16-bit external data bus |
| bus_mux | output | 1 | Multiplexed address bus |
| smode | output | 3 | Decoded special start mode |
| smode_err | output | 1 | Reserved special-mode code seen |
| adapt_en | output | 1 | Adapt mode request |
| emu_en | output | 1 | Emulation mode request |

## Verification
A wrong hold counter or delay selection shows up as `port_xpar` opening, or `cfg_strobe` firing, one or more cycles off the computed edge. The bench sees this in the same reset window. A wrong capture mask or a lost single-chip flag shows at `cfg_word` one cycle after the strobe, and at the decoded fields one cycle after that. Each scenario seeds the word so that every bit class (captured, kept, forced) holds a value that differs from the port. A write lock that fails shows on `cfg_word` on the cycle right after the ignored write.

// File: rtl/su_cfg_pkg.sv
package su_cfg_pkg;

  localparam int CFG_W = 16;

  typedef enum logic [1:0] {
    RK_POWERON = 2'd0,
    RK_LONGHW  = 2'd1,
    RK_SHORTHW = 2'd2,
    RK_SOFT    = 2'd3
  } rst_kind_e;

  typedef enum logic [2:0] {
    SM_NORMAL       = 3'd0,
    SM_BOOT         = 3'd1,
    SM_EXTHOST      = 3'd2,
    SM_CPUHOST      = 3'd3,
    SM_BOOT_CPUHOST = 3'd4
  } smode_e;

  localparam logic [CFG_W-1:0] MASK_ALL    = 16'hFFFF;
  localparam logic [CFG_W-1:0] MASK_SHORT  = 16'h1FFC;
  localparam logic [CFG_W-1:0] MASK_SOFT   = 16'h1FC0;
  localparam logic [CFG_W-1:0] MASK_SCHIP  = 16'hFF00;
  localparam logic [CFG_W-1:0] MASK_OPAQUE = 16'h0003;

  // Bits that a reset of this kind captures from the port.
  function automatic logic [CFG_W-1:0] sample_mask_f(rst_kind_e k, logic bidir, logic schip);
    logic [CFG_W-1:0] m;
    if (schip)                                        m = MASK_SCHIP;
    else if (bidir || k == RK_POWERON || k == RK_LONGHW) m = MASK_ALL;
    else if (k == RK_SHORTHW)                         m = MASK_SHORT;
    else                                              m = MASK_SOFT;
    return m;
  endfunction

endpackage

// File: rtl/su_window_ctrl.sv
module su_window_ctrl
  import su_cfg_pkg::*;
#(
  parameter int SEQ_TCL = 1024,
  parameter int PRE_DLY = 7,
  parameter int DIR_DLY = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rst_start,
  input  logic [1:0]       rst_kind,
  input  logic             bidir_en,
  input  logic             ext_access,
  input  logic             pin_rise,
  input  logic [2:0]       clk_code,
  output logic             strobe,
  output logic [CFG_W-1:0] samp_mask,
  output logic [CFG_W-1:0] xpar_mask,
  output logic             schip_load,
  output logic             hw_full
);

  localparam int HOLD_PON = 2 * SEQ_TCL;
  localparam int MAX_CNT  = (HOLD_PON > DIR_DLY) ? HOLD_PON : DIR_DLY;
  localparam int CNT_W    = $clog2(MAX_CNT + 1);
  localparam logic [CNT_W-1:0] LIM_PON  = CNT_W'(HOLD_PON - 1);
  localparam logic [CNT_W-1:0] LIM_SEQ  = CNT_W'(SEQ_TCL - 1);
  localparam logic [CNT_W-1:0] DLY_PRE  = CNT_W'(PRE_DLY);
  localparam logic [CNT_W-1:0] DLY_DIR  = CNT_W'(DIR_DLY);
  localparam logic [2:0]       CODE_PRE = 3'b001;

  typedef enum logic [1:0] {W_IDLE, W_HOLD, W_OPEN} wstate_e;

  wstate_e          state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] dly_q;
  rst_kind_e        kind_q;
  logic             bidir_q;
  logic             schip_q;
  logic             rise_q;

  logic [CNT_W-1:0] hold_lim;
  logic             timed_kind;
  logic             go_count;

  assign hold_lim   = (kind_q == RK_POWERON) ? LIM_PON : LIM_SEQ;
  assign timed_kind = (kind_q == RK_SHORTHW) || (kind_q == RK_SOFT);
  assign go_count   = timed_kind || rise_q;
  assign samp_mask  = sample_mask_f(kind_q, bidir_q, schip_q);
  assign schip_load = schip_q;
  assign hw_full    = (kind_q == RK_POWERON) || (kind_q == RK_LONGHW);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= W_IDLE;
      cnt_q     <= '0;
      dly_q     <= DLY_DIR;
      kind_q    <= RK_POWERON;
      bidir_q   <= 1'b0;
      schip_q   <= 1'b0;
      rise_q    <= 1'b0;
      strobe    <= 1'b0;
      xpar_mask <= '0;
    end else begin
      strobe <= 1'b0;
      if (rst_start) begin
        state_q   <= W_HOLD;
        cnt_q     <= '0;
        kind_q    <= rst_kind_e'(rst_kind);
        bidir_q   <= bidir_en;
        schip_q   <= ext_access &&
                     (rst_kind_e'(rst_kind) == RK_POWERON || rst_kind_e'(rst_kind) == RK_LONGHW);
        rise_q    <= 1'b0;
        dly_q     <= (clk_code == CODE_PRE) ? DLY_PRE : DLY_DIR;
        xpar_mask <= '0;
      end else begin
        unique case (state_q)
          W_HOLD: begin
            if (pin_rise) rise_q <= 1'b1;
            if (cnt_q == hold_lim) begin
              state_q   <= W_OPEN;
              cnt_q     <= '0;
              xpar_mask <= samp_mask & ~MASK_OPAQUE;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          W_OPEN: begin
            if (pin_rise) rise_q <= 1'b1;
            if (go_count) begin
              if (cnt_q == dly_q - 1'b1) begin
                strobe    <= 1'b1;
                state_q   <= W_IDLE;
                xpar_mask <= '0;
              end else begin
                cnt_q <= cnt_q + 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/su_cfg_store.sv
module su_cfg_store
  import su_cfg_pkg::*;
#(
  parameter logic [CFG_W-1:0] RESET_CFG = 16'hFFFF,
  parameter logic [7:0]       SC_LOW    = 8'h2B
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             strobe,
  input  logic [CFG_W-1:0] samp_mask,
  input  logic             schip_load,
  input  logic             hw_full,
  input  logic [CFG_W-1:0] port_in,
  input  logic             sw_we,
  input  logic [CFG_W-1:0] sw_data,
  input  logic             init_done,
  output logic [CFG_W-1:0] cfg_q,
  output logic             schip_mode_q
);

  logic [CFG_W-1:0] merged;

  always_comb begin
    merged = (cfg_q & ~samp_mask) | (port_in & samp_mask);
    if (schip_load) merged[7:0] = SC_LOW;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q        <= RESET_CFG;
      schip_mode_q <= 1'b0;
    end else if (strobe) begin
      cfg_q <= merged;
      if (hw_full) schip_mode_q <= schip_load;
    end else if (sw_we && !init_done) begin
      cfg_q <= sw_data;
    end
  end

endmodule

// File: rtl/su_cfg_decode.sv
module su_cfg_decode
  import su_cfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [CFG_W-1:0] cfg,
  input  logic             schip_mode,
  output logic [3:0]       clk_mult_x2,
  output logic [1:0]       seg_sel,
  output logic [1:0]       cs_sel,
  output logic             wr_mode,
  output logic             bus_16bit,
  output logic             bus_mux,
  output smode_e           smode,
  output logic             smode_err,
  output logic             adapt_en,
  output logic             emu_en
);

  logic [3:0] mult_c;
  smode_e     smode_c;
  logic       err_c;

  always_comb begin
    unique case (cfg[15:13])
      3'b111:  mult_c = 4'd8;
      3'b110:  mult_c = 4'd6;
      3'b101:  mult_c = 4'd4;
      3'b100:  mult_c = 4'd10;
      3'b011:  mult_c = 4'd2;
      3'b010:  mult_c = 4'd3;
      3'b001:  mult_c = 4'd1;
      default: mult_c = 4'd5;
    endcase
  end

  always_comb begin
    err_c = 1'b0;
    unique case (cfg[5:2])
      4'b1111: smode_c = SM_NORMAL;
      4'b1011: smode_c = SM_BOOT;
      4'b0111: smode_c = SM_EXTHOST;
      4'b1110: smode_c = SM_CPUHOST;
      4'b1010: smode_c = SM_BOOT_CPUHOST;
      default: begin
        smode_c = SM_NORMAL;
        err_c   = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_mult_x2 <= 4'd8;
      seg_sel     <= 2'b11;
      cs_sel      <= 2'b11;
      wr_mode     <= 1'b1;
      bus_16bit   <= 1'b1;
      bus_mux     <= 1'b1;
      smode       <= SM_NORMAL;
      smode_err   <= 1'b0;
      adapt_en    <= 1'b0;
      emu_en      <= 1'b0;
    end else begin
      clk_mult_x2 <= mult_c;
      seg_sel     <= cfg[12:11];
      cs_sel      <= cfg[10:9];
      wr_mode     <= cfg[8];
      bus_16bit   <= cfg[7];
      bus_mux     <= cfg[6];
      smode       <= smode_c;
      smode_err   <= err_c;
      adapt_en    <= ~cfg[1] & ~schip_mode;
      emu_en      <= ~cfg[0] & ~schip_mode;
    end
  end

endmodule

// File: rtl/startup_cfg_latch.sv
module startup_cfg_latch
  import su_cfg_pkg::*;
#(
  parameter int          SEQ_TCL   = 1024,
  parameter int          PRE_DLY   = 7,
  parameter int          DIR_DLY   = 10,
  parameter logic [15:0] RESET_CFG = 16'hFFFF,
  parameter logic [7:0]  SC_LOW    = 8'h2B
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        rst_start,
  input  logic [1:0]  rst_kind,
  input  logic        bidir_en,
  input  logic        ext_access,
  input  logic        pin_rise,
  input  logic [15:0] port_in,
  input  logic        sw_we,
  input  logic [15:0] sw_data,
  input  logic        init_done,
  output logic [15:0] port_xpar,
  output logic        cfg_strobe,
  output logic [15:0] cfg_word,
  output logic [3:0]  clk_mult_x2,
  output logic [1:0]  seg_sel,
  output logic [1:0]  cs_sel,
  output logic        wr_mode,
  output logic        bus_16bit,
  output logic        bus_mux,
  output logic [2:0]  smode,
  output logic        smode_err,
  output logic        adapt_en,
  output logic        emu_en
);

  logic [CFG_W-1:0] samp_mask;
  logic             schip_load;
  logic             hw_full;
  logic             schip_mode_q;
  smode_e           smode_e_q;

  su_window_ctrl #(
    .SEQ_TCL(SEQ_TCL),
    .PRE_DLY(PRE_DLY),
    .DIR_DLY(DIR_DLY)
  ) u_win (
    .clk        (clk),
    .rst        (rst),
    .rst_start  (rst_start),
    .rst_kind   (rst_kind),
    .bidir_en   (bidir_en),
    .ext_access (ext_access),
    .pin_rise   (pin_rise),
    .clk_code   (cfg_word[15:13]),
    .strobe     (cfg_strobe),
    .samp_mask  (samp_mask),
    .xpar_mask  (port_xpar),
    .schip_load (schip_load),
    .hw_full    (hw_full)
  );

  su_cfg_store #(
    .RESET_CFG(RESET_CFG),
    .SC_LOW   (SC_LOW)
  ) u_store (
    .clk          (clk),
    .rst          (rst),
    .strobe       (cfg_strobe),
    .samp_mask    (samp_mask),
    .schip_load   (schip_load),
    .hw_full      (hw_full),
    .port_in      (port_in),
    .sw_we        (sw_we),
    .sw_data      (sw_data),
    .init_done    (init_done),
    .cfg_q        (cfg_word),
    .schip_mode_q (schip_mode_q)
  );

  su_cfg_decode u_dec (
    .clk         (clk),
    .rst         (rst),
    .cfg         (cfg_word),
    .schip_mode  (schip_mode_q),
    .clk_mult_x2 (clk_mult_x2),
    .seg_sel     (seg_sel),
    .cs_sel      (cs_sel),
    .wr_mode     (wr_mode),
    .bus_16bit   (bus_16bit),
    .bus_mux     (bus_mux),
    .smode       (smode_e_q),
    .smode_err   (smode_err),
    .adapt_en    (adapt_en),
    .emu_en      (emu_en)
  );

  assign smode = smode_e_q;

endmodule

// File: rtl/su_cfg_checker.sv
module su_cfg_checker (
  input logic        clk,
  input logic        rst,
  input logic        rst_start,
  input logic        sw_we,
  input logic        init_done,
  input logic        cfg_strobe,
  input logic [15:0] port_xpar,
  input logic [15:0] cfg_word,
  input logic [2:0]  smode,
  input logic        smode_err,
  input logic        adapt_en,
  input logic        emu_en,
  input logic        schip_mode
);

  AST_LOW_BITS_OPAQUE: assert property (@(posedge clk) disable iff (rst)
    port_xpar[1:0] == 2'b00); // R4

  AST_START_CLOSES_WINDOW: assert property (@(posedge clk) disable iff (rst)
    rst_start |=> port_xpar == 16'h0000); // R2

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    cfg_strobe |=> !cfg_strobe); // R3

  AST_STROBE_WINDOW_SHUT: assert property (@(posedge clk) disable iff (rst)
    cfg_strobe |-> port_xpar == 16'h0000); // R3

  AST_SCHIP_NO_DEBUG: assert property (@(posedge clk) disable iff (rst)
    $past(schip_mode) |-> (!adapt_en && !emu_en)); // R8

  AST_RESERVED_AS_NORMAL: assert property (@(posedge clk) disable iff (rst)
    smode_err |-> smode == 3'd0); // R9

  AST_WRITE_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (sw_we && init_done && !cfg_strobe) |=> $stable(cfg_word)); // R12

endmodule

bind startup_cfg_latch su_cfg_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .rst_start  (rst_start),
  .sw_we      (sw_we),
  .init_done  (init_done),
  .cfg_strobe (cfg_strobe),
  .port_xpar  (port_xpar),
  .cfg_word   (cfg_word),
  .smode      (smode),
  .smode_err  (smode_err),
  .adapt_en   (adapt_en),
  .emu_en     (emu_en),
  .schip_mode (schip_mode_q)
);

// File: tb/startup_cfg_latch_tb.sv
module startup_cfg_latch_tb;

  localparam int SEQ = 64;
  localparam int DP  = 7;
  localparam int DD  = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rst_start = 1'b0;
  logic [1:0]  rst_kind = 2'd0;
  logic        bidir_en = 1'b0;
  logic        ext_access = 1'b0;
  logic        pin_rise = 1'b0;
  logic [15:0] port_in = 16'h0000;
  logic        sw_we = 1'b0;
  logic [15:0] sw_data = 16'h0000;
  logic        init_done = 1'b0;
  logic [15:0] port_xpar;
  logic        cfg_strobe;
  logic [15:0] cfg_word;
  logic [3:0]  clk_mult_x2;
  logic [1:0]  seg_sel;
  logic [1:0]  cs_sel;
  logic        wr_mode;
  logic        bus_16bit;
  logic        bus_mux;
  logic [2:0]  smode;
  logic        smode_err;
  logic        adapt_en;
  logic        emu_en;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  startup_cfg_latch #(.SEQ_TCL(SEQ), .PRE_DLY(DP), .DIR_DLY(DD)) u_dut (
    .clk(clk), .rst(rst), .rst_start(rst_start), .rst_kind(rst_kind),
    .bidir_en(bidir_en), .ext_access(ext_access), .pin_rise(pin_rise),
    .port_in(port_in), .sw_we(sw_we), .sw_data(sw_data), .init_done(init_done),
    .port_xpar(port_xpar), .cfg_strobe(cfg_strobe), .cfg_word(cfg_word),
    .clk_mult_x2(clk_mult_x2), .seg_sel(seg_sel), .cs_sel(cs_sel),
    .wr_mode(wr_mode), .bus_16bit(bus_16bit), .bus_mux(bus_mux),
    .smode(smode), .smode_err(smode_err), .adapt_en(adapt_en), .emu_en(emu_en)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_mult(input logic [2:0] c);
    case (c)
      3'b111: return 4'd8;
      3'b110: return 4'd6;
      3'b101: return 4'd4;
      3'b100: return 4'd10;
      3'b011: return 4'd2;
      3'b010: return 4'd3;
      3'b001: return 4'd1;
      default: return 4'd5;
    endcase
  endfunction

  // Runs one reset window; returns after decoded outputs are valid.
  task automatic run_reset(input logic [1:0] kind, input logic bd, input logic ea,
                           input logic [15:0] port, input int rise_at, input int hold,
                           input int exp_strobe, input logic [15:0] exp_xpar, input string tag);
    int got;
    got = -1;
    @(negedge clk);
    rst_start = 1'b1; rst_kind = kind; bidir_en = bd; ext_access = ea; port_in = port;
    @(negedge clk);
    rst_start = 1'b0;
    for (int n = 0; n < 4000; n++) begin
      if (n == hold - 1) check({tag, " R2 closed before hold end"}, {16'h0, port_xpar}, 32'h0);
      if (n == hold) check({tag, " R2/R4 open mask"}, {16'h0, port_xpar}, {16'h0, exp_xpar});
      if (cfg_strobe) begin
        got = n;
        break;
      end
      pin_rise = (n == rise_at);
      @(negedge clk);
    end
    pin_rise = 1'b0;
    check({tag, " R3 strobe cycle"}, got, exp_strobe);
    @(negedge clk);
    check({tag, " R3 strobe single"}, {31'h0, cfg_strobe}, 32'h0);
    @(negedge clk);
  endtask

  task automatic sw_write(input logic [15:0] d);
    @(negedge clk);
    sw_we = 1'b1; sw_data = d;
    @(negedge clk);
    sw_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset_state;
    check("R1 cfg_word", {16'h0, cfg_word}, 32'hFFFF);
    check("R1 xpar", {16'h0, port_xpar}, 32'h0);
    check("R1 strobe", {31'h0, cfg_strobe}, 32'h0);
    check("R1 mult", {28'h0, clk_mult_x2}, 32'd8);
    check("R1 smode/err/adapt/emu", {26'h0, smode, smode_err, adapt_en, emu_en}, 32'h0);
  endtask

  task automatic t_poweron_full;
    run_reset(2'd0, 1'b0, 1'b0, 16'h26AD, 140, 2*SEQ, 140 + 1 + DD, 16'hFFFC, "PON");
    check("R7 pon word", {16'h0, cfg_word}, 32'h26AD);
    check("R11 mult /2", {28'h0, clk_mult_x2}, 32'd1);
    check("R10 fields", {24'h0, seg_sel, cs_sel, wr_mode, bus_16bit, bus_mux, 1'b0},
          {24'h0, 2'b00, 2'b11, 1'b0, 1'b1, 1'b0, 1'b0});
    check("R9 loader", {29'h0, smode}, 32'd1);
    check("R10 adapt/emu", {30'h0, adapt_en, emu_en}, 32'b10);
  endtask

  task automatic t_short_hw;
    run_reset(2'd2, 1'b0, 1'b0, 16'hFFFF, -1, SEQ, SEQ + DP, 16'h1FFC, "SHWR");
    check("R5 short keeps 15:13 1:0", {16'h0, cfg_word}, 32'h3FFD);
    check("R9 normal", {28'h0, smode, smode_err}, 32'h0);
  endtask

  task automatic t_soft;
    run_reset(2'd3, 1'b0, 1'b0, 16'h0000, -1, SEQ, SEQ + DP, 16'h1FC0, "SWR");
    check("R6 soft keeps 15:13 5:0", {16'h0, cfg_word}, 32'h203D);
    check("R10 bus 8-bit demux", {30'h0, bus_16bit, bus_mux}, 32'h0);
  endtask

  task automatic t_soft_bidir;
    run_reset(2'd3, 1'b1, 1'b0, 16'hEDC3, -1, SEQ, SEQ + DP, 16'hFFFC, "SWR-BD");
    check("R7 bidir full", {16'h0, cfg_word}, 32'hEDC3);
    check("R11 mult x4", {28'h0, clk_mult_x2}, 32'd8);
    check("R9 reserved", {28'h0, smode, smode_err}, {28'h0, 3'd0, 1'b1});
    check("R10 fields", {24'h0, seg_sel, cs_sel, wr_mode, bus_16bit, bus_mux, 1'b0},
          {24'h0, 2'b01, 2'b10, 1'b1, 1'b1, 1'b1, 1'b0});
  endtask

  task automatic t_sw_writes;
    logic [15:0] last;
    last = 16'h0;
    for (int i = 0; i < 8; i++) begin
      logic [3:0] code;
      logic [2:0] exp_sm;
      logic       exp_err;
      case (i)
        0: begin code = 4'b1111; exp_sm = 3'd0; exp_err = 1'b0; end
        1: begin code = 4'b1011; exp_sm = 3'd1; exp_err = 1'b0; end
        2: begin code = 4'b0111; exp_sm = 3'd2; exp_err = 1'b0; end
        3: begin code = 4'b1110; exp_sm = 3'd3; exp_err = 1'b0; end
        4: begin code = 4'b1010; exp_sm = 3'd4; exp_err = 1'b0; end
        5: begin code = 4'b0000; exp_sm = 3'd0; exp_err = 1'b1; end
        6: begin code = 4'b0101; exp_sm = 3'd0; exp_err = 1'b1; end
        default: begin code = 4'b1100; exp_sm = 3'd0; exp_err = 1'b1; end
      endcase
      last = {3'(i), 5'b00000, 2'(i), code, 2'b11};
      sw_write(last);
      check("R12 write loads", {16'h0, cfg_word}, {16'h0, last});
      check("R11 mult table", {28'h0, clk_mult_x2}, {28'h0, exp_mult(3'(i))});
      check("R9 smode table", {28'h0, smode, smode_err}, {28'h0, exp_sm, exp_err});
      check("R10 bus bits", {30'h0, bus_16bit, bus_mux}, {30'h0, 2'(i)});
    end
    init_done = 1'b1;
    sw_write(16'h0000);
    check("R12 locked write ignored", {16'h0, cfg_word}, {16'h0, last});
  endtask

  task automatic t_single_chip;
    init_done = 1'b0;
    run_reset(2'd1, 1'b0, 1'b1, 16'h60FC, 10, SEQ, SEQ + DD, 16'hFF00, "LHWR-SC");
    check("R8 fixed low byte", {16'h0, cfg_word}, 32'h602B);
    check("R9 loader+host", {29'h0, smode}, 32'd4);
    check("R11 mult x1", {28'h0, clk_mult_x2}, 32'd2);
    sw_write(16'hFFFC);
    check("R12 write after sc", {16'h0, cfg_word}, 32'hFFFC);
    check("R8 adapt/emu blocked", {30'h0, adapt_en, emu_en}, 32'h0);
    run_reset(2'd0, 1'b0, 1'b0, 16'hFFFC, 150, 2*SEQ, 150 + 1 + DD, 16'hFFFC, "PON-CLR");
    check("R8 cleared adapt/emu", {30'h0, adapt_en, emu_en}, 32'b11);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_state();
    t_poweron_full();
    t_short_hw();
    t_soft();
    t_soft_bidir();
    t_sw_writes();
    t_single_chip();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule